// File: doc/BRIEF.md
# Parallel Configuration Byte Receiver

This block plays the device side of a byte-wide parallel configuration port. A verification environment uses it to check a host controller. While the host holds the configuration-start line low, the receiver stays in reset and pulls its open-drain status line low. Once the line is released, the receiver leaves reset and lets go of the status line. From then on, each write strobe rising edge that arrives while the chip select pair is active latches one byte from the data bus.

After each byte, the receiver lowers its ready flag for a fixed number of cycles of its own clock. That clock stands in for an internal oscillator of roughly 10 MHz. A write that arrives while the receiver is busy is flagged as an overrun, and its byte is dropped. When the read strobe is held low, the receiver turns bus bit 7 into an output that carries the ready flag. It raises a contention flag if the host drives the bus at the same time.

Accepted bytes come out with a one-cycle valid pulse and a running count. All host strobes are synchronized to the internal clock before their edges are detected.

Top module: `pcfg_byte_rx`

## Requirements
- R1: While `cfg_start_n` is low, the receiver is held in reset. In reset, `status_pull_low` is 1, `byte_count` is 0, `ready` is 1, `byte_valid` and `overrun` are 0, and `bus_hi_oe` is 0. A low level on `cfg_start_n` clears this state without waiting for a clock edge.
- R2: After `cfg_start_n` rises, `status_pull_low` is still 1 after the first rising clock edge. It is 0 after the second.
- R3: The receiver is selected when `sel_n` is 0 and `sel` is 1. A `wr_n` rising edge while selected and ready stores `bus_in`. `byte_out` then equals that byte, `byte_valid` pulses for one cycle, and `byte_count` increments by 1.
- R4: A `wr_n` rising edge while not selected has no effect. `byte_count` stays the same, `ready` stays 1, and neither `byte_valid` nor `overrun` pulses.
- R5: After a byte is stored, `ready` is 0 for exactly `PROC_CYCLES` clock cycles and then returns to 1.
- R6: A selected `wr_n` rising edge while `ready` is 0 pulses `overrun` for one cycle. It stores nothing, leaves `byte_count` unchanged and does not lengthen the busy interval.
- R7: The third rising clock edge after `rd_n` falls sets `bus_hi_oe` to 1. While `bus_hi_oe` is 1, `bus_hi_out` equals `ready`. The third rising clock edge after `rd_n` rises sets `bus_hi_oe` back to 0.
- R8: `contention` is 1 exactly when `bus_hi_oe` and `host_bus_oe` are both 1.
- R9: `byte_count` is `COUNT_W` bits wide and wraps from its maximum value to 0.
- R10: `byte_valid` and the fall of `ready` appear on the third rising clock edge after the `wr_n` rise, and not earlier. The host must hold `bus_in` and the select lines steady until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal processing clock |
| cfg_start_n | input | 1 | Configuration start; low holds reset |
| status_pull_low | output | 1 | Open-drain status line drive-low enable |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| wr_n | input | 1 | Write strobe; byte taken on rising edge |
| rd_n | input | 1 | Status read strobe, active low |
| bus_in | input | 8 | Configuration data bus as seen by the receiver |
| host_bus_oe | input | 1 | Host is driving the data bus |
| bus_hi_out | output | 1 | Value the receiver drives on bus bit 7 |
| bus_hi_oe | output | 1 | Receiver drives bus bit 7 |
| contention | output | 1 | Both sides drive the bus |
| ready | output | 1 | 1 = can take a byte, 0 = busy |
| byte_out | output | 8 | Last stored byte |
| byte_valid | output | 1 | One-cycle pulse when a byte is stored |
| byte_count | output | COUNT_W | Number of stored bytes, wrapping |
| overrun | output | 1 | One-cycle pulse on a write while busy |

## Verification
Several properties are checked on every cycle:
- a selected write while ready yields a valid pulse that carries the sampled byte;
- a write while busy yields an overrun and leaves the count stable;
- ready drops right after a load and stays high while nothing is loaded;
- the bus drive stays off after the read strobe has been high for three cycles;
- reset holds the status drive and clears the count.

Other behaviours only the bench scenarios can show: the exact length of the busy window, the three-edge latency of a write, the wrap of the count, that an unselected write is ignored, and the contention flag under host drive.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] cfg_byte_t;

  function automatic logic [31:0] busy_next(input logic [31:0] cur, input logic load,
                                            input logic [31:0] span);
    if (load) return span;
    if (cur != 0) return cur - 1;
    return cur;
  endfunction

  function automatic logic [31:0] count_next(input logic [31:0] cur, input logic inc,
                                             input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return inc ? ((cur + 32'd1) & mask) : cur;
  endfunction

endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_V}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/pcfg_busy_timer.sv
module pcfg_busy_timer #(
  parameter int unsigned PROC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  import pcfg_pkg::*;
  localparam int unsigned CW = $clog2(PROC_CYCLES + 1);

  logic [CW-1:0] remain;
  logic [31:0]   nxt;

  always_comb nxt = busy_next(32'(remain), load, 32'(PROC_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else        remain <= nxt[CW-1:0];
  end

  assign ready = (remain == '0);

  p_busy_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load) |=> ready);
endmodule

// File: rtl/pcfg_byte_capture.sv
module pcfg_byte_capture #(
  parameter int unsigned COUNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_rise,
  input  logic                  selected,
  input  logic                  ready,
  input  pcfg_pkg::cfg_byte_t   data,
  output logic                  load,
  output pcfg_pkg::cfg_byte_t   byte_out,
  output logic                  byte_valid,
  output logic                  overrun,
  output logic [COUNT_W-1:0]    byte_count
);
  import pcfg_pkg::*;

  logic        take_ev;
  logic        late_ev;
  logic [31:0] cnt_nxt;

  assign take_ev = wr_rise && selected && ready;
  assign late_ev = wr_rise && selected && !ready;
  assign load    = take_ev;

  always_comb cnt_nxt = count_next(32'(byte_count), take_ev, COUNT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_out   <= '0;
      byte_valid <= 1'b0;
      overrun    <= 1'b0;
      byte_count <= '0;
    end else begin
      byte_valid <= take_ev;
      overrun    <= late_ev;
      byte_count <= cnt_nxt[COUNT_W-1:0];
      if (take_ev) byte_out <= data;
    end
  end

  p_capture_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> (byte_valid && byte_out == $past(data)));
  p_overrun_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    late_ev |=> (overrun && !byte_valid && $stable(byte_count)));
endmodule

// File: rtl/pcfg_byte_rx.sv
module pcfg_byte_rx #(
  parameter int unsigned PROC_CYCLES = 8,
  parameter int unsigned COUNT_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               cfg_start_n,
  output logic               status_pull_low,
  input  logic               sel_n,
  input  logic               sel,
  input  logic               wr_n,
  input  logic               rd_n,
  input  logic [7:0]         bus_in,
  input  logic               host_bus_oe,
  output logic               bus_hi_out,
  output logic               bus_hi_oe,
  output logic               contention,
  output logic               ready,
  output logic [7:0]         byte_out,
  output logic               byte_valid,
  output logic [COUNT_W-1:0] byte_count,
  output logic               overrun
);
  import pcfg_pkg::*;

  // reset: asserted at once by cfg_start_n low, released through a synchronizer
  logic [SYNC_STAGES-1:0] rst_chain;
  logic                   rst_n;
  always_ff @(posedge clk or negedge cfg_start_n) begin
    if (!cfg_start_n) rst_chain <= '0;
    else              rst_chain <= {rst_chain[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n           = rst_chain[SYNC_STAGES-1];
  assign status_pull_low = !rst_n;

  // strobe synchronizers, idle high
  logic [1:0] strb_s;
  pcfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_strb (
    .clk(clk), .rst_n(rst_n), .d({rd_n, wr_n}), .q(strb_s));

  logic wr_s, rd_s, wr_d, wr_rise;
  assign wr_s = strb_s[0];
  assign rd_s = strb_s[1];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_d <= 1'b1;
    else        wr_d <= wr_s;
  end
  assign wr_rise = wr_s && !wr_d;

  logic selected, load;
  assign selected = !sel_n && sel;

  pcfg_byte_capture #(.COUNT_W(COUNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .selected(selected),
    .ready(ready), .data(bus_in), .load(load), .byte_out(byte_out),
    .byte_valid(byte_valid), .overrun(overrun), .byte_count(byte_count));

  pcfg_busy_timer #(.PROC_CYCLES(PROC_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(load), .ready(ready));

  // status readback on bus bit 7
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_hi_oe <= 1'b0;
    else        bus_hi_oe <= !rd_s;
  end
  assign bus_hi_out = bus_hi_oe && ready;
  assign contention = bus_hi_oe && host_bus_oe;

  p_reset_hold_r1: assert property (@(posedge clk)
    !cfg_start_n |-> (status_pull_low && byte_count == '0 && !bus_hi_oe));
  p_oe_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_n, 3) && $past(rd_n, 2) && $past(rd_n, 1)) |-> !bus_hi_oe);
endmodule

// File: tb/sim_pcfg_byte_rx.sv
`timescale 1ns/1ps
module sim_pcfg_byte_rx;
  localparam int P  = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_start_n, sel_n, sel, wr_n, rd_n, host_bus_oe;
  logic [7:0] bus_in;
  logic status_pull_low, bus_hi_out, bus_hi_oe, contention, ready, byte_valid, overrun;
  logic [7:0] byte_out;
  logic [CW-1:0] byte_count;

  pcfg_byte_rx #(.PROC_CYCLES(P), .COUNT_W(CW)) u0 (
    .clk(clk), .cfg_start_n(cfg_start_n), .status_pull_low(status_pull_low),
    .sel_n(sel_n), .sel(sel), .wr_n(wr_n), .rd_n(rd_n), .bus_in(bus_in),
    .host_bus_oe(host_bus_oe), .bus_hi_out(bus_hi_out), .bus_hi_oe(bus_hi_oe),
    .contention(contention), .ready(ready), .byte_out(byte_out),
    .byte_valid(byte_valid), .byte_count(byte_count), .overrun(overrun));

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  int exp_cnt = 0;
  int ovr_seen = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (cfg_start_n === 1'b1 && overrun === 1'b1) ovr_seen++;
    if (cfg_start_n === 1'b1 && byte_valid === 1'b1) begin
      if (exp_q.size() == 0) chk(0, "R4 unexpected byte", 32'(byte_out), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        exp_cnt = (exp_cnt + 1) % (1 << CW);
        chk(byte_out == e, "R3 byte value", 32'(byte_out), 32'(e));
        chk(byte_count == exp_cnt[CW-1:0], "R9 count", 32'(byte_count), 32'(exp_cnt));
      end
    end
  end

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); bus_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
  endtask

  // driver: send a byte expected to be stored, then wait for ready
  task automatic send(input logic [7:0] d);
    exp_q.push_back(d);
    pulse_wr(d);
    repeat (4) @(negedge clk);
    while (ready !== 1'b1) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
    end
  end

  initial begin
    cfg_start_n = 1'b0; sel_n = 1'b1; sel = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
    host_bus_oe = 1'b0; bus_in = 8'h00;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(status_pull_low === 1'b1, "R1 status low", 32'(status_pull_low), 1);
    chk(byte_count === '0, "R1 count", 32'(byte_count), 0);
    chk(ready === 1'b1 && bus_hi_oe === 1'b0, "R1 ready/oe", {ready, bus_hi_oe}, 2);
    // R2 release timing
    cfg_start_n = 1'b1;
    @(negedge clk);
    chk(status_pull_low === 1'b1, "R2 after 1 edge", 32'(status_pull_low), 1);
    @(negedge clk);
    chk(status_pull_low === 1'b0, "R2 after 2 edges", 32'(status_pull_low), 0);
    repeat (2) @(negedge clk);

    // R10 latency and R5 busy length
    sel_n = 1'b0; sel = 1'b1;
    exp_q.push_back(8'hA5);
    pulse_wr(8'hA5);             // wr_n rose just now
    @(negedge clk);              // after edge 1
    chk(byte_valid === 1'b0 && ready === 1'b1, "R10 edge1", {byte_valid, ready}, 1);
    @(negedge clk);              // after edge 2
    chk(byte_valid === 1'b0 && ready === 1'b1, "R10 edge2", {byte_valid, ready}, 1);
    @(negedge clk);              // after edge 3
    chk(byte_valid === 1'b1 && ready === 1'b0, "R10 edge3", {byte_valid, ready}, 2);
    begin
      int lowc = 1;
      while (ready === 1'b0 && lowc < 100) begin @(negedge clk); if (ready === 1'b0) lowc++; end
      chk(lowc == P, "R5 busy length", lowc, P);
    end

    // R3 various patterns
    send(8'h00); send(8'hFF); send(8'h5A); send(8'h81);

    // R4 not selected (sel_n high, then sel low)
    begin
      logic [CW-1:0] c0;
      c0 = byte_count;
      sel_n = 1'b1;
      pulse_wr(8'h33);
      repeat (5) @(negedge clk);
      chk(byte_count == c0 && ready === 1'b1, "R4 sel_n high ignored", 32'(byte_count), 32'(c0));
      sel_n = 1'b0; sel = 1'b0;
      pulse_wr(8'h44);
      repeat (5) @(negedge clk);
      chk(byte_count == c0 && ready === 1'b1, "R4 sel low ignored", 32'(byte_count), 32'(c0));
      chk(ovr_seen == 0, "R4 no overrun", ovr_seen, 0);
      sel = 1'b1;
    end

    // R6 overrun while busy
    begin
      logic [CW-1:0] c0;
      int busyc;
      c0 = byte_count;
      exp_q.push_back(8'h12);
      pulse_wr(8'h12);
      repeat (4) @(negedge clk);   // stored, busy
      pulse_wr(8'hEE);
      busyc = 0;
      repeat (5) @(negedge clk);
      chk(ovr_seen == 1, "R6 overrun pulse", ovr_seen, 1);
      chk(byte_count == c0 + 1'b1, "R6 count unchanged", 32'(byte_count), 32'(c0 + 1'b1));
      chk(byte_out == 8'h12, "R6 byte kept", 32'(byte_out), 32'h12);
      while (ready !== 1'b1 && busyc < 100) begin @(negedge clk); busyc++; end
      chk(busyc <= P, "R6 busy not lengthened", busyc, P);
    end

    // R7 / R8 status on bus bit 7
    rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(bus_hi_oe === 1'b0, "R7 oe before sync", 32'(bus_hi_oe), 0);
    @(negedge clk);
    chk(bus_hi_oe === 1'b1 && bus_hi_out === 1'b1, "R7 oe idle ready", {bus_hi_oe, bus_hi_out}, 3);
    chk(contention === 1'b0, "R8 no host drive", 32'(contention), 0);
    host_bus_oe = 1'b1;
    #1 chk(contention === 1'b1, "R8 contention", 32'(contention), 1);
    host_bus_oe = 1'b0;
    exp_q.push_back(8'h77);
    pulse_wr(8'h77);
    repeat (3) @(negedge clk);
    chk(bus_hi_oe === 1'b1 && bus_hi_out === 1'b0, "R7 busy on bit7", {bus_hi_oe, bus_hi_out}, 2);
    while (ready !== 1'b1) @(negedge clk);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_hi_oe === 1'b0, "R7 oe released", 32'(bus_hi_oe), 0);
    host_bus_oe = 1'b1;
    #1 chk(contention === 1'b0, "R8 host only", 32'(contention), 0);
    host_bus_oe = 1'b0;

    // R9 wrap of count
    for (int i = 0; i < 18; i++) send(8'(i * 13 + 1));
    chk(byte_count == exp_cnt[CW-1:0], "R9 wrapped count", 32'(byte_count), 32'(exp_cnt));
    chk(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);

    // R1 reset mid-operation
    pulse_wr(8'h99);
    repeat (3) @(negedge clk);
    cfg_start_n = 1'b0;
    #1;
    chk(status_pull_low === 1'b1 && byte_count === '0, "R1 async reset", 32'(byte_count), 0);
    chk(ready === 1'b1 && byte_valid === 1'b0 && overrun === 1'b0, "R1 reset outputs",
        {ready, byte_valid, overrun}, 4);
    exp_q.delete();
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end
endmodule